// File: doc/BRIEF.md
# Operand Bypass and Pipeline Interlock Controller

This controller handles hazards in a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory and write-back. Every instruction passes through all five stages. Registers are read in decode and written only at write-back, so the only hazard it has to check is read-after-write. The datapath, ALU and register file sit outside the block.

Each cycle the block looks at the two source register numbers of the instruction in decode. It compares them with the destinations of the instructions now in execute and in memory. From that comparison it registers a bypass select for each ALU operand, and the select applies in the next cycle, when the decode instruction has moved into execute.

Two conditions stop fetch. The first is a load in execute whose destination the decode instruction reads. The second is the single shared memory port carrying a data access. In either case the block holds the PC and the fetch/decode register in the same cycle and turns the instruction entering execute into a no-op. The register file writes in the first half of a cycle and reads in the second half, so a producer three slots ahead never needs a bypass.

Top module: `fwd_interlock_unit`

## Requirements
- R1: While `rst` is sampled high at a clock edge, both operand selects become 0 (the register file value) after that edge.
- R2: Select encoding is 0 for the register file, 1 for the execute/memory pipeline register and 2 for the memory/write-back pipeline register. If there is no stall and a decode source equals `ex_rd` with `ex_we` high and `ex_rd` nonzero, that operand's select is 1 after the next clock edge.
- R3: If there is no stall, a decode source does not match a writing execute producer, and it equals `mem_rd` with `mem_we` high and `mem_rd` nonzero, that operand's select is 2 after the next edge.
- R4: When a source matches both a writing execute producer and a writing memory producer, the select after the edge is 1, because the younger result wins.
- R5: A source of register 0 always gets select 0 and never causes a load interlock.
- R6: A stage whose write enable is low is never forwarded from and never causes an interlock.
- R7: In the same cycle, `hold_pc_ifid` and `bubble_idex` are high when `ex_is_load` and `ex_we` are both high and the nonzero `ex_rd` equals either decode source.
- R8: In the same cycle, `hold_pc_ifid` and `bubble_idex` are high whenever `mem_dacc` is high.
- R9: When none of the conditions in R7 and R8 holds, `hold_pc_ifid` and `bubble_idex` are low.
- R10: In a stall cycle, both selects registered at the following edge are 0, because a no-op enters execute.
- R11: A load sitting in the memory stage does not stall. A matching decode source gets select 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_dacc | input | 1 | Shared memory port busy with a data access |
| fwd_a | output | 2 | Registered bypass select for ALU operand A |
| fwd_b | output | 2 | Registered bypass select for ALU operand B |
| hold_pc_ifid | output | 1 | Hold the PC and the fetch/decode register |
| bubble_idex | output | 1 | Clear the decode/execute control fields to a no-op |

## Verification
The hardest case to reach is a stall cycle in which both a load interlock and a forwarding match are present. In that cycle the registered selects must fall back to 0 rather than pick a bypass. Another hard case is a source matching both producers at once. To reach them, the stimulus draws register numbers from a pool of only four values, including register 0, and randomises the write, load and memory-busy flags. A behavioural model checks every cycle. Directed steps come first to pin down the priority, register-0, load-distance and memory-port cases.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_src_select.sv
module fwd_src_select
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic             stall,
  output fwd_sel_e         sel_next
);
  logic hit_ex, hit_mem, rs_zero;

  always_comb begin
    rs_zero = (rs == '0);
    hit_ex  = ex_we  && !rs_zero && (ex_rd  == rs);
    hit_mem = mem_we && !rs_zero && (mem_rd == rs);
    // a bubble enters execute on a stall, so no bypass is needed
    if (stall)        sel_next = SEL_RF;
    else if (hit_ex)  sel_next = SEL_EXMEM;  // younger result first (R4)
    else if (hit_mem) sel_next = SEL_MEMWB;
    else              sel_next = SEL_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0][REG_W-1:0] rs,
  input  logic [REG_W-1:0]            ex_rd,
  input  logic                        ex_we,
  input  logic                        ex_is_load,
  output logic                        hit
);
  logic [N_SRC-1:0] per_src;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign per_src[i] = (rs[i] == ex_rd);
  end

  assign hit = ex_is_load && ex_we && (ex_rd != '0) && (|per_src);
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic             mem_dacc,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             hold_pc_ifid,
  output logic             bubble_idex
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0][REG_W-1:0] src;
  fwd_sel_e [N_SRC-1:0]        sel_next;
  fwd_sel_e [N_SRC-1:0]        sel_q;
  logic                        lu_hit, stall;

  assign src[0] = id_rs1;
  assign src[1] = id_rs2;

  load_use_detect #(.REG_W(REG_W), .N_SRC(N_SRC)) u_lu (
    .rs(src), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load), .hit(lu_hit)
  );

  // structural stall from the shared port, or the load interlock
  assign stall        = lu_hit || mem_dacc;
  assign hold_pc_ifid = stall;
  assign bubble_idex  = stall;

  for (genvar i = 0; i < N_SRC; i++) begin : g_op
    fwd_src_select #(.REG_W(REG_W)) u_sel (
      .rs(src[i]), .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd),
      .mem_we(mem_we), .stall(stall), .sel_next(sel_next[i])
    );
    always_ff @(posedge clk) begin
      if (rst) sel_q[i] <= SEL_RF;
      else     sel_q[i] <= sel_next[i];
    end
  end

  assign fwd_a = sel_q[0];
  assign fwd_b = sel_q[1];

  p_loaduse_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load && ex_we && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2))
      |-> (hold_pc_ifid && bubble_idex));

  p_memport_stall_r8: assert property (@(posedge clk) disable iff (rst)
    mem_dacc |-> (hold_pc_ifid && bubble_idex));

  p_stall_clears_r10: assert property (@(posedge clk) disable iff (rst)
    hold_pc_ifid |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

  p_exmem_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold_pc_ifid && ex_we && ex_rd != '0 && ex_rd == id_rs1) |=> (fwd_a == 2'd1));

  p_zero_src_r5: assert property (@(posedge clk) disable iff (rst)
    (id_rs2 == '0) |=> (fwd_b == 2'd0));
endmodule

// File: tb/fwd_interlock_unit_tb.sv
module fwd_interlock_unit_tb;
  localparam int REG_W = 5;

  logic clk = 0;
  logic rst = 1;
  logic [REG_W-1:0] id_rs1 = 0, id_rs2 = 0, ex_rd = 0, mem_rd = 0;
  logic ex_we = 0, ex_is_load = 0, mem_we = 0, mem_dacc = 0;
  logic [1:0] fwd_a, fwd_b;
  logic hold_pc_ifid, bubble_idex;

  int n_checks = 0;
  int n_fail = 0;
  int exp_a = 0, exp_b = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fwd_interlock_unit #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rd(ex_rd),
    .ex_we(ex_we), .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_dacc(mem_dacc), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .hold_pc_ifid(hold_pc_ifid), .bubble_idex(bubble_idex)
  );

  function automatic bit model_stall();
    bit lu;
    lu = ex_is_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    return lu || mem_dacc;
  endfunction

  function automatic int model_sel(input logic [REG_W-1:0] rs);
    if (model_stall()) return 0;
    if (rs == 0) return 0;
    if (ex_we && ex_rd == rs) return 1;
    if (mem_we && mem_rd == rs) return 2;
    return 0;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive inputs after a falling edge, check same-cycle stall, then check the
  // selects registered at the following rising edge.
  task automatic step(input logic [REG_W-1:0] r1, input logic [REG_W-1:0] r2,
                      input logic [REG_W-1:0] erd, input logic ewe, input logic eld,
                      input logic [REG_W-1:0] mrd, input logic mwe, input logic mda,
                      input string tag);
    bit st;
    @(negedge clk);
    id_rs1 = r1; id_rs2 = r2; ex_rd = erd; ex_we = ewe; ex_is_load = eld;
    mem_rd = mrd; mem_we = mwe; mem_dacc = mda;
    #1;
    st = model_stall();
    check(int'(hold_pc_ifid), int'(st), {tag, " hold"});
    check(int'(bubble_idex), int'(st), {tag, " bubble"});
    exp_a = model_sel(r1);
    exp_b = model_sel(r2);
    @(negedge clk);
    check(int'(fwd_a), exp_a, {tag, " fwd_a"});
    check(int'(fwd_b), exp_b, {tag, " fwd_b"});
  endtask

  initial begin
    id_rs1 = 3; ex_rd = 3; ex_we = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(int'(fwd_a), 0, "R1 reset fwd_a");
    check(int'(fwd_b), 0, "R1 reset fwd_b");
    rst = 0;

    step(5, 6, 5, 1, 0, 6, 1, 0, "R2 exmem");
    step(7, 8, 1, 1, 0, 8, 1, 0, "R3 memwb");
    step(9, 9, 9, 1, 0, 9, 1, 0, "R4 priority");
    step(0, 0, 0, 1, 1, 0, 1, 0, "R5 reg zero");
    step(4, 0, 4, 0, 1, 4, 0, 0, "R6 no write");
    step(2, 10, 10, 1, 1, 2, 1, 0, "R7 load use");
    step(11, 12, 11, 1, 0, 12, 1, 1, "R8 port busy");
    step(13, 14, 15, 1, 0, 16, 1, 0, "R9 no hazard");
    step(3, 3, 3, 1, 1, 3, 1, 0, "R10 stall clears");
    step(17, 18, 19, 1, 0, 17, 1, 0, "R11 load in mem");

    for (int i = 0; i < 3000; i++) begin
      step(REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
           REG_W'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
           REG_W'($urandom_range(0, 3)), 1'($urandom),
           1'($urandom_range(0, 5) == 0), "R2-random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule